// File: doc/BRIEF.md
# Configuration Copy-and-Verify Engine

This block copies a device's configuration bytes into an external byte-addressed EEPROM and then proves that the copy is correct. It starts on a one-cycle start pulse. It walks a configured address range in ascending order, reads each byte from internal memory and writes it to the EEPROM at the same address. Address windows that hold receive data or log storage are listed as parameters and are stepped over. When the write pass ends, the block walks the same addresses again. It reads each byte back from the EEPROM and compares it with the internal byte.

The ready output drops the cycle after the start pulse and rises again only when every compared byte matches. On the first mismatch the block stops the comparison and captures the failing address. It then latches a sticky programming-error flag, raises the interrupt and parks in a safe state. It stays there until the host pulses the clear input.

Each EEPROM access is a request that is held steady until the EEPROM acknowledges it, so write cycles of any length are tolerated. The serial link to the EEPROM is outside this block.

Top module: `cfg_burn_verify`

## Requirements
- R1: After reset, ready is 1, ee_req is 0, prog_err is 0 and irq is 0.
- R2: A start pulse sampled while ready is 1 drives ready to 0 on the next clock edge. Ready stays 0 while any EEPROM request is outstanding.
- R3: In the write pass, every address from FIRST to LAST that lies outside the skip windows is written once, in ascending order. The data written is the internal byte at that same address (ee_we = 1).
- R4: Addresses inside a skip window, and addresses outside FIRST..LAST, are never requested in either pass. Skip windows are inclusive, may be adjacent, and are listed in ascending order.
- R5: The read pass (ee_we = 0) starts only after the last write is acknowledged. It reads the same addresses in the same ascending order.
- R6: A request keeps ee_req, ee_addr and ee_we unchanged until the cycle in which ee_ack is 1. That cycle completes the access.
- R7: If every read-back byte equals the internal byte, ready returns to 1 after the last read is acknowledged, and prog_err stays 0.
- R8: On the first read-back byte that differs from the internal byte, prog_err becomes 1, irq becomes 1 and ready stays 0. The block issues no further EEPROM requests, and err_addr holds the failing address.
- R9: A start pulse is ignored while a pass is running or while prog_err is 1. A clear pulse while prog_err is 1 sets prog_err and irq to 0 and ready to 1 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a copy-and-verify cycle |
| mem_addr | output | AW | Internal memory read address |
| mem_rdata | input | 8 | Internal memory byte at mem_addr, same cycle |
| ee_req | output | 1 | EEPROM access request, held until acknowledged |
| ee_we | output | 1 | 1 = write access, 0 = read access |
| ee_addr | output | AW | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_rdata | input | 8 | Byte read, valid while ee_ack is 1 on a read |
| ee_ack | input | 1 | Access complete |
| ready | output | 1 | 1 when idle and no error is pending |
| irq | output | 1 | Interrupt, asserted while the programming error is pending |
| prog_err | output | 1 | Sticky programming-error flag |
| err_addr | output | AW | Address of the first mismatching byte |
| err_clr | input | 1 | Host clear of the programming error |

## Verification
The bench builds the block with a 6-bit address space, a copy range of 4 to 59, and three skip windows: 10–15, 16–19 and 40–47. The first two windows are adjacent, so the skip stepping has to chain across them. The small space lets the bench inspect every EEPROM byte after a clean pass. It also lets the bench plant a read-back fault at each of the 38 copied addresses in turn, from the first to the last. Each fault run confirms the captured address, how far the read pass got, and the safe-state and clear behaviour. The EEPROM model varies its acknowledge delay with the address, so requests are held for zero to two extra cycles.

// File: rtl/cfg_burn_verify.sv
module cfg_burn_verify #(
  parameter int AW = 16,
  parameter logic [AW-1:0] FIRST = 16'h0000,
  parameter logic [AW-1:0] LAST = 16'h807F,
  parameter int NSKIP = 2,
  parameter logic [NSKIP*AW-1:0] SKIP_LO = {16'h3000, 16'h0000},
  parameter logic [NSKIP*AW-1:0] SKIP_HI = {16'h33FF, 16'h2FFF}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          ee_req,
  output logic          ee_we,
  output logic [AW-1:0] ee_addr,
  output logic [7:0]    ee_wdata,
  input  logic [7:0]    ee_rdata,
  input  logic          ee_ack,
  output logic          ready,
  output logic          irq,
  output logic          prog_err,
  output logic [AW-1:0] err_addr,
  input  logic          err_clr
);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_SAFE} state_t;

  function automatic logic [AW:0] step_over(input logic [AW:0] a);
    logic [AW:0] r;
    r = a;
    for (int i = 0; i < NSKIP; i++) begin
      if (r >= {1'b0, SKIP_LO[i*AW +: AW]} && r <= {1'b0, SKIP_HI[i*AW +: AW]})
        r = {1'b0, SKIP_HI[i*AW +: AW]} + 1'b1;
    end
    return r;
  endfunction

  localparam logic [AW:0] START_X = step_over({1'b0, FIRST});

  state_t        st;
  logic [AW-1:0] addr;
  logic [AW:0]   nxt;
  logic          at_end;

  assign nxt      = step_over({1'b0, addr} + 1'b1);
  assign at_end   = nxt > {1'b0, LAST};
  assign ee_req   = (st == S_WR) || (st == S_RD);
  assign ee_we    = (st == S_WR);
  assign ee_addr  = addr;
  assign mem_addr = addr;
  assign ee_wdata = mem_rdata;
  assign irq      = prog_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr     <= '0;
      ready    <= 1'b1;
      prog_err <= 1'b0;
      err_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st    <= S_WR;
          addr  <= START_X[AW-1:0];
          ready <= 1'b0;
        end
        S_WR: if (ee_ack) begin
          if (at_end) begin
            st   <= S_RD;
            addr <= START_X[AW-1:0];
          end else begin
            addr <= nxt[AW-1:0];
          end
        end
        S_RD: if (ee_ack) begin
          if (ee_rdata != mem_rdata) begin
            st       <= S_SAFE;
            prog_err <= 1'b1;
            err_addr <= addr;
          end else if (at_end) begin
            st    <= S_IDLE;
            ready <= 1'b1;
          end else begin
            addr <= nxt[AW-1:0];
          end
        end
        default: if (err_clr) begin
          st       <= S_IDLE;
          prog_err <= 1'b0;
          ready    <= 1'b1;
        end
      endcase
    end
  end

endmodule

module cfg_burn_verify_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] FIRST = 16'h0000,
  parameter logic [AW-1:0] LAST = 16'h807F,
  parameter int NSKIP = 2,
  parameter logic [NSKIP*AW-1:0] SKIP_LO = {16'h3000, 16'h0000},
  parameter logic [NSKIP*AW-1:0] SKIP_HI = {16'h33FF, 16'h2FFF}
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ee_req,
  input logic          ee_we,
  input logic [AW-1:0] ee_addr,
  input logic          ee_ack,
  input logic          ready,
  input logic          irq,
  input logic          prog_err,
  input logic          err_clr
);

  function automatic logic allowed(input logic [AW-1:0] a);
    logic ok;
    ok = (a >= FIRST) && (a <= LAST);
    for (int i = 0; i < NSKIP; i++)
      if (a >= SKIP_LO[i*AW +: AW] && a <= SKIP_HI[i*AW +: AW]) ok = 1'b0;
    return ok;
  endfunction

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req |-> !ready);

  a_r4_skip_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req |-> allowed(ee_addr));

  a_r5_no_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_we) |=> !(ee_req && ee_we));

  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr) && $stable(ee_we)));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_err && !err_clr) |=> prog_err);

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err |-> (!ee_req && !ready && irq));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_err && err_clr) |=> (!prog_err && ready && !irq));

endmodule

bind cfg_burn_verify cfg_burn_verify_chk #(
  .AW(AW), .FIRST(FIRST), .LAST(LAST), .NSKIP(NSKIP),
  .SKIP_LO(SKIP_LO), .SKIP_HI(SKIP_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ee_req(ee_req), .ee_we(ee_we),
  .ee_addr(ee_addr), .ee_ack(ee_ack), .ready(ready), .irq(irq),
  .prog_err(prog_err), .err_clr(err_clr)
);

// File: tb/cfg_burn_verify_bench.sv
module cfg_burn_verify_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int FIRST = 4;
  localparam int LAST = 59;
  localparam int NCFG = 38;

  logic clk = 0, rst_n = 0, start = 0, err_clr = 0;
  logic [AW-1:0] mem_addr, ee_addr, err_addr;
  logic [7:0] mem_rdata, ee_wdata, ee_rdata;
  logic ee_req, ee_we, ee_ack, ready, irq, prog_err;

  logic [7:0] imem [64];
  logic [7:0] eem [64];
  int checks = 0, errors = 0;
  int wr_cnt, rd_cnt, seq_err, exp_wr, exp_rd, wt;
  bit fault_en = 0;
  int fault_addr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = imem[mem_addr];

  cfg_burn_verify #(
    .AW(AW), .FIRST(6'd4), .LAST(6'd59), .NSKIP(3),
    .SKIP_LO({6'd40, 6'd16, 6'd10}), .SKIP_HI({6'd47, 6'd19, 6'd15})
  ) u_cfg_burn_verify (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr),
    .ee_wdata(ee_wdata), .ee_rdata(ee_rdata), .ee_ack(ee_ack), .ready(ready),
    .irq(irq), .prog_err(prog_err), .err_addr(err_addr), .err_clr(err_clr)
  );

  function automatic bit skipped(int a);
    return (a >= 10 && a <= 15) || (a >= 16 && a <= 19) || (a >= 40 && a <= 47);
  endfunction

  function automatic int next_cfg(int a);
    int r = a + 1;
    while (r <= LAST && skipped(r)) r++;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic prep(input int pat, input bit fen, input int fa);
    for (int a = 0; a < 64; a++) begin
      imem[a] = 8'(a * 37 + pat);
      eem[a] = 8'hEE;
    end
    wr_cnt = 0; rd_cnt = 0; seq_err = 0;
    exp_wr = next_cfg(FIRST - 1); exp_rd = exp_wr;
    fault_en = fen; fault_addr = fa;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(ready || prog_err) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(n < 3000, "R7 pass completes", n, 0);
  endtask

  // EEPROM model: acknowledge delay of (addr % 3) extra cycles
  initial begin
    ee_ack = 0; ee_rdata = 0; wt = 0;
    forever begin
      @(negedge clk);
      if (ee_ack) ee_ack = 0;
      else if (ee_req) begin
        if (wt < (int'(ee_addr) % 3)) wt++;
        else begin
          wt = 0;
          if (ee_we) begin
            if (int'(ee_addr) != exp_wr || rd_cnt != 0 || ee_wdata != imem[ee_addr]) seq_err++;
            eem[ee_addr] = ee_wdata;
            wr_cnt++;
            exp_wr = next_cfg(exp_wr);
          end else begin
            if (int'(ee_addr) != exp_rd || wr_cnt != NCFG) seq_err++;
            ee_rdata = eem[ee_addr] ^ ((fault_en && int'(ee_addr) == fault_addr) ? 8'h01 : 8'h00);
            rd_cnt++;
            exp_rd = next_cfg(exp_rd);
          end
          ee_ack = 1;
        end
      end
    end
  end

  task automatic clean_run(input int pat);
    int bad_cp = 0, bad_sk = 0;
    prep(pat, 0, 0);
    pulse_start();
    check(ready == 0, "R2 ready low after start", ready, 0);
    repeat (20) @(negedge clk);
    pulse_start();  // R9: ignored while busy
    wait_end();
    check(ready == 1 && prog_err == 0 && irq == 0, "R7 clean end", {ready, prog_err, irq}, 3'b100);
    check(wr_cnt == NCFG, "R3 write count", wr_cnt, NCFG);
    check(rd_cnt == NCFG, "R5 read count", rd_cnt, NCFG);
    check(seq_err == 0, "R3 R5 access order and data", seq_err, 0);
    for (int a = 0; a < 64; a++) begin
      if (a >= FIRST && a <= LAST && !skipped(a)) begin
        if (eem[a] != imem[a]) bad_cp++;
      end else if (eem[a] != 8'hEE) bad_sk++;
    end
    check(bad_cp == 0, "R3 copied bytes", bad_cp, 0);
    check(bad_sk == 0, "R4 skipped bytes untouched", bad_sk, 0);
    repeat (5) @(negedge clk);
    check(ee_req == 0 && wr_cnt == NCFG, "R9 start while busy ignored", wr_cnt, NCFG);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ready == 1 && ee_req == 0 && prog_err == 0 && irq == 0, "R1 reset state",
          {ready, ee_req, prog_err, irq}, 4'b1000);

    clean_run(0);
    clean_run(91);

    // R8: a read-back fault at every copied address in turn
    begin
      int k = 0;
      for (int a = FIRST; a <= LAST; a++) begin
        if (!skipped(a)) begin
          prep(a * 5, 1, a);
          pulse_start();
          wait_end();
          check(prog_err == 1 && irq == 1 && ready == 0, "R8 safe state",
                {prog_err, irq, ready}, 3'b110);
          check(int'(err_addr) == a, "R8 error address", err_addr, a);
          check(rd_cnt == k + 1, "R8 reads stop at mismatch", rd_cnt, k + 1);
          check(seq_err == 0 && wr_cnt == NCFG, "R5 order before mismatch", seq_err, 0);
          pulse_start();
          repeat (8) @(negedge clk);
          check(prog_err == 1 && ee_req == 0 && rd_cnt == k + 1, "R9 start ignored in safe state",
                rd_cnt, k + 1);
          @(negedge clk) err_clr = 1;
          @(negedge clk) err_clr = 0;
          check(ready == 1 && prog_err == 0 && irq == 0, "R9 clear",
                {ready, prog_err, irq}, 3'b100);
          k++;
        end
      end
      check(k == NCFG, "R4 copied address count", k, NCFG);
    end

    clean_run(200);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule